// File: doc/BRIEF.md
# NAND flash read responder

This block sits behind a 16-bit general-purpose I/O port and plays the part of a small-page NAND flash that software drives by toggling port lines. It watches two active-low chip enables, a read strobe, a write strobe, an address-latch line and a command-latch line. It takes read commands and three address bytes, and hands back sequential bytes on the low eight port bits. It also drives one ready line per chip and controls the direction of the data bits.

Two chip-select banks are served, each with its own mode, address pointer and address-cycle counter. Each bank's content is a fixed pattern computed from the byte address, so no storage is needed. A page is 528 bytes. The read command picks the first half, the second half or the spare area of a page. The address bytes arrive as column, then high page byte, then low page byte. The block reacts only when the read or write strobe changes level. Malformed sequences raise a sticky protocol-error output.

Top module: `nand_rd_responder`

## Requirements
- R1: After reset, port_out and port_oe are all zero, proto_err is 0, both banks are idle and both address pointers are 0.
- R2: The block acts only on a sampled change of port bit 10 (read strobe, active low) or port bit 11 (write strobe, active low). Changes on any other line while both strobes hold their level have no effect on any output or on the address pointer.
- R3: A strobe change while port bits 8 and 9 (chip enables, active low) are both high changes no output and does not advance any address pointer.
- R4: Bit 8 low selects bank 0 and bit 9 low selects bank 1. When both are low, bank 0 is selected.
- R5: With bit 13 (command latch) high and the write strobe low, port bits [7:0] are a command. 0xFF returns the bank to idle. 0x00, 0x01 and 0x50 enter read modes A, B and spare. Each read command clears the address-cycle counter.
- R6: With bit 12 (address latch) high, bit 13 low and the write strobe low, bits [7:0] are an address byte. The first byte sets the pointer to the byte plus 0x000, 0x100 or 0x200 for modes A, B and spare. The second byte adds byte×528×256. The third byte adds byte×528.
- R7: A read-strobe low event that is neither a command nor an address drives the byte at the selected bank's pointer on port_out[7:0] with port_oe[7:0]=0xFF, then increments that pointer.
- R8: When both strobes are high after a change, port_oe[7:0] returns to 0. For the selected bank b, port_out[14+b] and port_oe[14+b] are set to 1 and stay set.
- R9: The byte at address A of bank b is A[7:0]^A[15:8]^A[23:16]^A[31:24]^seed_b, with seed 0x00 for bank 0 and 0xA5 for bank 1.
- R10: A fourth address byte, or an address byte while the bank is idle, sets proto_err and leaves the pointer unchanged. proto_err stays 1 until reset.
- R11: A command code other than the four listed sets proto_err and leaves the bank's mode, cycle counter and pointer unchanged.
- R12: Each bank keeps its own mode, cycle counter and pointer. Traffic to one bank never moves the other's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | 16 | Levels of the GPIO port lines |
| port_out | output | 16 | Values the responder imposes: data in [7:0], ready in [15:14] |
| port_oe | output | 16 | Per-bit drive enables matching port_out |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest situation to create from the ports is a line change that must be ignored. This means a command-latch line and data byte changing while the read strobe is already held low, and a full read strobe with no chip enabled. Neither produces any output edge of its own. So the bench holds the strobe, changes the other lines, and checks that the driven byte stays put. It then proves the address pointer did not move by doing one more ordinary read and comparing it with the next expected pattern byte. Error cases are each started from a fresh reset, because the error flag is sticky.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

   localparam int BIT_CE0  = 8;
   localparam int BIT_CE1  = 9;
   localparam int BIT_RE   = 10;
   localparam int BIT_WE   = 11;
   localparam int BIT_ALE  = 12;
   localparam int BIT_CLE  = 13;
   localparam int BIT_RDY0 = 14;

   localparam logic [7:0] CMD_RESET    = 8'hFF;
   localparam logic [7:0] CMD_RD_A     = 8'h00;
   localparam logic [7:0] CMD_RD_B     = 8'h01;
   localparam logic [7:0] CMD_RD_SPARE = 8'h50;

   typedef enum logic [1:0] {
      MODE_IDLE,
      MODE_RD_A,
      MODE_RD_B,
      MODE_RD_SPARE
   } nfr_mode_e;

   typedef struct packed {
      logic idle;
      logic cmd;
      logic addr;
      logic rd;
   } nfr_ev_t;

   function automatic logic [7:0] nfr_pattern(input logic [31:0] a, input logic [7:0] seed);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ seed;
   endfunction

endpackage

// File: rtl/nfr_line_decode.sv
module nfr_line_decode
   import nfr_pkg::*;
#(
   parameter int NUM_BANKS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [13:0]          lines,
   output logic                 strobe_edge,
   output nfr_ev_t              ev,
   output logic [NUM_BANKS-1:0] bank_sel,
   output logic [7:0]           bus_byte
);

   localparam logic [13:0] QUIET_LINES = 14'((1 << BIT_CE0) | (1 << BIT_CE1) |
                                             (1 << BIT_RE)  | (1 << BIT_WE));

   logic [13:0] smp_q;
   logic [13:0] smp_qq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= QUIET_LINES;
         smp_qq <= QUIET_LINES;
      end else begin
         smp_q  <= lines;
         smp_qq <= smp_q;
      end
   end

   assign strobe_edge = (smp_q[BIT_RE] ^ smp_qq[BIT_RE]) | (smp_q[BIT_WE] ^ smp_qq[BIT_WE]);
   assign bus_byte    = smp_q[7:0];

   generate
      if (NUM_BANKS == 1) begin : g_one
         assign bank_sel[0] = ~smp_q[BIT_CE0];
      end else begin : g_two
         assign bank_sel[0] = ~smp_q[BIT_CE0];
         assign bank_sel[1] = smp_q[BIT_CE0] & ~smp_q[BIT_CE1];
      end
   endgenerate

   logic re_hi, we_hi;
   assign re_hi = smp_q[BIT_RE];
   assign we_hi = smp_q[BIT_WE];

   always_comb begin
      ev = '0;
      if (strobe_edge && (|bank_sel)) begin
         if (re_hi && we_hi)                ev.idle = 1'b1;
         else if (smp_q[BIT_CLE] && !we_hi) ev.cmd  = 1'b1;
         else if (smp_q[BIT_ALE] && !we_hi) ev.addr = 1'b1;
         else if (!re_hi)                   ev.rd   = 1'b1;
      end
   end

endmodule

// File: rtl/nfr_bank.sv
module nfr_bank
   import nfr_pkg::*;
#(
   parameter int         ADDR_W     = 26,
   parameter int         PAGE_BYTES = 528,
   parameter logic [7:0] SEED       = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  nfr_ev_t    ev,
   input  logic [7:0] bus_byte,
   output logic [7:0] rd_byte,
   output logic       fault
);

   localparam logic [ADDR_W-1:0] LO_STEP = ADDR_W'(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(PAGE_BYTES * 256);

   nfr_mode_e         mode_q;
   logic [1:0]        cyc_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] col_base;
   logic              cmd_known;
   logic              addr_bad;

   always_comb begin
      case (mode_q)
         MODE_RD_B:     col_base = ADDR_W'(12'h100);
         MODE_RD_SPARE: col_base = ADDR_W'(12'h200);
         default:       col_base = '0;
      endcase
   end

   assign cmd_known = (bus_byte == CMD_RESET) || (bus_byte == CMD_RD_A) ||
                      (bus_byte == CMD_RD_B)  || (bus_byte == CMD_RD_SPARE);
   assign addr_bad  = (mode_q == MODE_IDLE) || (cyc_q == 2'd3);
   assign fault     = hit && ((ev.cmd && !cmd_known) || (ev.addr && addr_bad));
   assign rd_byte   = nfr_pattern(32'(ptr_q), SEED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_IDLE;
         cyc_q  <= '0;
         ptr_q  <= '0;
      end else if (hit) begin
         if (ev.cmd) begin
            case (bus_byte)
               CMD_RESET:    mode_q <= MODE_IDLE;
               CMD_RD_A:     begin mode_q <= MODE_RD_A;     cyc_q <= '0; end
               CMD_RD_B:     begin mode_q <= MODE_RD_B;     cyc_q <= '0; end
               CMD_RD_SPARE: begin mode_q <= MODE_RD_SPARE; cyc_q <= '0; end
               default:      ;
            endcase
         end else if (ev.addr && !addr_bad) begin
            case (cyc_q)
               2'd0:    ptr_q <= ADDR_W'(bus_byte) + col_base;
               2'd1:    ptr_q <= ptr_q + ADDR_W'(bus_byte) * HI_STEP;
               default: ptr_q <= ptr_q + ADDR_W'(bus_byte) * LO_STEP;
            endcase
            cyc_q <= cyc_q + 2'd1;
         end else if (ev.rd) begin
            ptr_q <= ptr_q + ADDR_W'(1);
         end
      end
   end

endmodule

// File: rtl/nand_rd_responder.sv
module nand_rd_responder
   import nfr_pkg::*;
#(
   parameter int                  PORT_W     = 16,
   parameter int                  NUM_BANKS  = 2,
   parameter int                  PAGE_BYTES = 528,
   parameter int                  ADDR_W     = 26,
   parameter logic [2*8-1:0]      BANK_SEEDS = 16'hA5_00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_in,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_oe,
   output logic              proto_err
);

   localparam longint MAX_PTR = 64'd767 + 64'd255 * PAGE_BYTES * 256 + 64'd255 * PAGE_BYTES;

   generate
      if (PORT_W != 16)                  begin : g_bad_port  $error("PORT_W must be 16"); end
      if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks $error("NUM_BANKS must be 1 or 2"); end
      if (ADDR_W > 32)                   begin : g_bad_wide  $error("ADDR_W must not exceed 32"); end
      if (MAX_PTR >= (64'd1 << ADDR_W))  begin : g_bad_narrow $error("ADDR_W too small for page geometry"); end
   endgenerate

   logic                 strobe_edge;
   nfr_ev_t              ev;
   logic [NUM_BANKS-1:0] bank_sel;
   logic [7:0]           bus_byte;
   logic [7:0]           bank_byte [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_fault;
   logic [7:0]           sel_byte;
   logic                 unused_ready_lines;

   assign unused_ready_lines = ^port_in[PORT_W-1:BIT_RDY0];

   nfr_line_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .lines       (port_in[13:0]),
      .strobe_edge (strobe_edge),
      .ev          (ev),
      .bank_sel    (bank_sel),
      .bus_byte    (bus_byte)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      nfr_bank #(
         .ADDR_W     (ADDR_W),
         .PAGE_BYTES (PAGE_BYTES),
         .SEED       (BANK_SEEDS[8*b +: 8])
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (bank_sel[b]),
         .ev       (ev),
         .bus_byte (bus_byte),
         .rd_byte  (bank_byte[b]),
         .fault    (bank_fault[b])
      );
   end

   always_comb begin
      sel_byte = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_sel[b]) sel_byte = sel_byte | bank_byte[b];
      end
   end

   logic                 rd_hit, idle_hit;
   logic [7:0]           data_q;
   logic                 data_oe_q;
   logic [NUM_BANKS-1:0] ready_q;
   logic                 err_q;

   assign rd_hit   = ev.rd;
   assign idle_hit = ev.idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         data_oe_q <= 1'b0;
         ready_q   <= '0;
         err_q     <= 1'b0;
      end else begin
         if (rd_hit) begin
            data_q    <= sel_byte;
            data_oe_q <= 1'b1;
         end
         if (idle_hit) begin
            data_oe_q <= 1'b0;
            ready_q   <= ready_q | bank_sel;
         end
         if (|bank_fault) err_q <= 1'b1;
      end
   end

   always_comb begin
      port_out      = '0;
      port_oe       = '0;
      port_out[7:0] = data_q;
      port_oe[7:0]  = {8{data_oe_q}};
      for (int b = 0; b < NUM_BANKS; b++) begin
         port_out[BIT_RDY0 + b] = ready_q[b];
         port_oe[BIT_RDY0 + b]  = ready_q[b];
      end
   end

   assign proto_err = err_q;

endmodule

// File: rtl/nfr_checker.sv
module nfr_checker
   import nfr_pkg::*;
#(
   parameter int PORT_W    = 16,
   parameter int NUM_BANKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [PORT_W-1:0]    port_out,
   input logic [PORT_W-1:0]    port_oe,
   input logic                 proto_err,
   input logic                 strobe_edge,
   input logic [NUM_BANKS-1:0] bank_sel,
   input logic                 rd_hit,
   input logic                 idle_hit
);

   AST_QUIET_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_edge |=> $stable(port_out) && $stable(port_oe) && $stable(proto_err)); // R2

   AST_NO_SELECT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_edge && bank_sel == '0) |=> $stable(port_out) && $stable(port_oe) && $stable(proto_err)); // R3

   AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_oe[0]) |-> $past(rd_hit)); // R7

   AST_RELEASE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hit |=> port_oe[7:0] == 8'h00); // R8

   AST_READY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      port_out[BIT_RDY0] |=> port_out[BIT_RDY0]); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err); // R10

endmodule

bind nand_rd_responder nfr_checker #(.PORT_W(PORT_W), .NUM_BANKS(NUM_BANKS)) u_nfr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .port_out    (port_out),
   .port_oe     (port_oe),
   .proto_err   (proto_err),
   .strobe_edge (strobe_edge),
   .bank_sel    (bank_sel),
   .rd_hit      (rd_hit),
   .idle_hit    (idle_hit)
);

// File: tb/nand_rd_responder_bench.sv
`timescale 1ns/1ps
module nand_rd_responder_bench;

   localparam logic [15:0] B0   = 16'h0E00;
   localparam logic [15:0] B1   = 16'h0D00;
   localparam logic [15:0] BOTH = 16'h0C00;
   localparam logic [15:0] NONE = 16'h0F00;
   localparam logic [15:0] RE   = 16'h0400;
   localparam logic [15:0] WE   = 16'h0800;
   localparam logic [15:0] ALE  = 16'h1000;
   localparam logic [15:0] CLE  = 16'h2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] port_in = NONE;
   logic [15:0] port_out, port_oe;
   logic        proto_err;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   nand_rd_responder u_nand_rd_responder (
      .clk(clk), .rst_n(rst_n), .port_in(port_in),
      .port_out(port_out), .port_oe(port_oe), .proto_err(proto_err)
   );

   function automatic logic [7:0] pat(input logic [31:0] a, input logic [7:0] seed);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ seed;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input logic [15:0] v);
      @(negedge clk);
      port_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      port_in = NONE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cmd(input logic [15:0] ce, input logic [7:0] c);
      step(ce | CLE | 16'(c));
      step((ce | CLE | 16'(c)) & ~WE);
      step(ce | CLE | 16'(c));
      step(ce);
   endtask

   task automatic adr(input logic [15:0] ce, input logic [7:0] a);
      step(ce | ALE | 16'(a));
      step((ce | ALE | 16'(a)) & ~WE);
      step(ce | ALE | 16'(a));
      step(ce);
   endtask

   task automatic rd(input logic [15:0] ce, output logic [7:0] b, output logic [7:0] oe);
      step(ce & ~RE);
      b  = port_out[7:0];
      oe = port_oe[7:0];
      step(ce);
   endtask

   task automatic t_reset_state();
      chk("R1 port_out", 32'(port_out), 32'h0);
      chk("R1 port_oe", 32'(port_oe), 32'h0);
      chk("R1 proto_err", 32'(proto_err), 32'h0);
   endtask

   task automatic t_read_mode_a();
      logic [7:0] b, oe;
      cmd(B0, 8'h00); adr(B0, 8'h10); adr(B0, 8'h01); adr(B0, 8'h02);
      for (int i = 0; i < 3; i++) begin
         rd(B0, b, oe);
         chk("R6 R7 R9 mode A byte", 32'(b), 32'(pat(136240 + i, 8'h00)));
         chk("R7 drive enable", 32'(oe), 32'hFF);
      end
      chk("R8 released", 32'(port_oe[7:0]), 32'h0);
      chk("R8 ready0", 32'({port_out[14], port_oe[14]}), 32'h3);
   endtask

   task automatic t_read_mode_b_bank1();
      logic [7:0] b, oe;
      cmd(B1, 8'h01); adr(B1, 8'h05); adr(B1, 8'h00); adr(B1, 8'h00);
      for (int i = 0; i < 2; i++) begin
         rd(B1, b, oe);
         chk("R6 R9 mode B bank1 byte", 32'(b), 32'(pat(32'h105 + i, 8'hA5)));
      end
      chk("R8 ready1", 32'({port_out[15], port_oe[15]}), 32'h3);
   endtask

   task automatic t_read_spare();
      logic [7:0] b, oe;
      cmd(B0, 8'h50); adr(B0, 8'h0F); adr(B0, 8'h00); adr(B0, 8'h03);
      rd(B0, b, oe);
      chk("R6 spare byte", 32'(b), 32'(pat(2111, 8'h00)));
   endtask

   task automatic t_cycle_restart();
      logic [7:0] b, oe;
      cmd(B0, 8'h00); adr(B0, 8'h01); adr(B0, 8'h02);
      cmd(B0, 8'h00); adr(B0, 8'h03); adr(B0, 8'h00); adr(B0, 8'h00);
      rd(B0, b, oe);
      chk("R5 restart byte", 32'(b), 32'(pat(3, 8'h00)));
      chk("R5 no error", 32'(proto_err), 32'h0);
   endtask

   task automatic t_ce_priority();
      logic [7:0] b, oe;
      cmd(BOTH, 8'h00); adr(BOTH, 8'h07); adr(BOTH, 8'h00); adr(BOTH, 8'h00);
      rd(BOTH, b, oe);
      chk("R4 bank0 wins", 32'(b), 32'(pat(7, 8'h00)));
      rd(B1, b, oe);
      chk("R4 R12 bank1 untouched", 32'(b), 32'(pat(32'h107, 8'hA5)));
   endtask

   task automatic t_banks_independent();
      logic [7:0] b, oe;
      cmd(B0, 8'h00); adr(B0, 8'h20); adr(B0, 8'h00); adr(B0, 8'h00);
      cmd(B1, 8'h00); adr(B1, 8'h40); adr(B1, 8'h00); adr(B1, 8'h00);
      rd(B0, b, oe); chk("R12 bank0", 32'(b), 32'(pat(32'h20, 8'h00)));
      rd(B1, b, oe); chk("R12 bank1", 32'(b), 32'(pat(32'h40, 8'hA5)));
      rd(B0, b, oe); chk("R12 bank0 next", 32'(b), 32'(pat(32'h21, 8'h00)));
   endtask

   task automatic t_no_select();
      logic [7:0] b, oe;
      step(NONE & ~RE);
      chk("R3 no drive", 32'(port_oe[7:0]), 32'h0);
      chk("R3 data held", 32'(port_out[7:0]), 32'(pat(32'h21, 8'h00)));
      step(NONE);
      rd(B0, b, oe);
      chk("R3 pointer not advanced", 32'(b), 32'(pat(32'h22, 8'h00)));
   endtask

   task automatic t_edges_only();
      logic [7:0] b, oe;
      step(B0 & ~RE);
      chk("R2 read", 32'(port_out[7:0]), 32'(pat(32'h23, 8'h00)));
      step((B0 & ~RE) | CLE | 16'h00FF);
      chk("R2 byte held", 32'(port_out[7:0]), 32'(pat(32'h23, 8'h00)));
      chk("R2 still driving", 32'(port_oe[7:0]), 32'hFF);
      step(B0 & ~RE);
      step(B0);
      rd(B0, b, oe);
      chk("R2 one increment", 32'(b), 32'(pat(32'h24, 8'h00)));
      chk("R2 no error", 32'(proto_err), 32'h0);
   endtask

   task automatic t_bad_command();
      logic [7:0] b, oe;
      do_reset();
      cmd(B0, 8'h00); adr(B0, 8'h01);
      cmd(B0, 8'h33);
      chk("R11 error set", 32'(proto_err), 32'h1);
      adr(B0, 8'h00); adr(B0, 8'h00);
      rd(B0, b, oe);
      chk("R11 state kept", 32'(b), 32'(pat(1, 8'h00)));
   endtask

   task automatic t_extra_address();
      logic [7:0] b, oe;
      do_reset();
      cmd(B0, 8'h00); adr(B0, 8'h01); adr(B0, 8'h00); adr(B0, 8'h00);
      chk("R10 clean", 32'(proto_err), 32'h0);
      adr(B0, 8'h09);
      chk("R10 fourth byte", 32'(proto_err), 32'h1);
      rd(B0, b, oe);
      chk("R10 pointer kept", 32'(b), 32'(pat(1, 8'h00)));
   endtask

   task automatic t_addr_in_idle();
      do_reset();
      cmd(B0, 8'hFF);
      adr(B0, 8'h05);
      chk("R10 idle address", 32'(proto_err), 32'h1);
      cmd(B0, 8'h00);
      chk("R10 sticky", 32'(proto_err), 32'h1);
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_read_mode_a();
      t_read_mode_b_bank1();
      t_read_spare();
      t_cycle_restart();
      t_ce_priority();
      t_banks_independent();
      t_no_select();
      t_edges_only();
      t_bad_command();
      t_extra_address();
      t_addr_in_idle();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule